// File: doc/BRIEF.md
# I2C Interrupt Status and Vector Unit

This unit collects the event flags of an I2C master controller and turns them into one interrupt request plus a small coded vector. The transfer engine reports each event as a single-cycle pulse: arbitration lost, missing acknowledge, access ready, receive ready, transmit ready, receive overrun and transmit underflow. It also supplies a bus-busy level. Each pulse sets a sticky flag in a 16-bit status register. Software clears a flag by writing a one to it.

Software reaches the unit through a plain register port. A status register, an interrupt-enable register and a read-only vector register are mapped there. Older driver code works with the vector register. A read of it returns the code of one enabled, pending source and clears that source at the same clock edge. Newer code reads the status register, acknowledges flags with write-one-to-clear, and leaves the vector register unused.

The read data is combinational: `reg_rdata` shows the register selected by `reg_addr` in the same cycle. Writes take effect at the next rising edge. The clearing side effect of a vector read also takes effect at the edge where `reg_rd` is high. Address map: 0 = status, 1 = interrupt enable, 2 = vector, 3 = reserved.

Top module: `i2c_irq_vec_unit`

## Requirements
- R1: After reset, every status bit is 0 apart from the bus-busy bit 12, which follows `bus_busy`. The enable register reads 0, the vector reads 0 and `irq` is low.
- R2: An event pulse sets its status bit at the next edge, and the bit then stays set until it is cleared. The status bit positions are: arbitration lost 0, no acknowledge 1, access ready 2, receive ready 3, transmit ready 4, transmit underflow 10, receive overrun 11. Bits 8, 9 and 15 and every other unlisted bit read 0.
- R3: A write to address 0 clears each sticky status bit whose data bit is 1. Status bits whose data bit is 0 keep their value.
- R4: Status bit 12 always equals the `bus_busy` input, and writes do not change it.
- R5: The enable register (address 1) stores data bits 4:0, one enable for each of status bits 4:0. Bits 15:5 read 0.
- R6: `irq` is high exactly while at least one of status bits 4:0 is set and its enable bit is also set. Status bits 10 and 11 never raise `irq`.
- R7: The vector register (address 2) reads 0 when no enabled source is pending. Otherwise it reads 1 for arbitration lost, 2 for no acknowledge, 3 for access ready, 4 for receive ready or 5 for transmit ready. A pending source whose enable is 0 is never reported.
- R8: When several enabled sources are pending, the vector reports the one with the lowest code.
- R9: A vector read clears only the status bit it reports, and the other bits keep their value. A status read clears nothing.
- R10: When an event pulse arrives in the same cycle as a clear of that bit (a status write or a vector read), the bit ends up set.
- R11: Writes to address 2 or 3 change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_arb_lost | input | 1 | Arbitration-lost event pulse |
| ev_nack | input | 1 | No-acknowledge event pulse |
| ev_acc_rdy | input | 1 | Access-ready event pulse |
| ev_rx_rdy | input | 1 | Receive-data-ready event pulse |
| ev_tx_rdy | input | 1 | Transmit-data-ready event pulse |
| ev_tx_udf | input | 1 | Transmit-underflow event pulse |
| ev_rx_ovr | input | 1 | Receive-overrun event pulse |
| bus_busy | input | 1 | Bus-busy level |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (only has an effect at address 2) |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of the selected register |
| irq | output | 1 | Interrupt request |

## Verification
Two functions can act on the same flag in one cycle: an event pulse setting it, and a clear. The clear can come from a write-one-to-clear or from a vector read. The bench provokes this by driving the pulse and the clearing access in the same cycle. Afterwards it reads the status register and judges that the flag is still set, and for the vector case it also checks that the returned code was the expected one. Priority among several pending sources is checked by draining the vector one read at a time and comparing each returned code with the expected order.

// File: rtl/i2civ_pkg.sv
package i2civ_pkg;

    localparam int DATA_W  = 16;
    localparam int NUM_SRC = 5;

    localparam int BIT_AL   = 0;
    localparam int BIT_NACK = 1;
    localparam int BIT_ARDY = 2;
    localparam int BIT_RRDY = 3;
    localparam int BIT_XRDY = 4;
    localparam int BIT_XUDF = 10;
    localparam int BIT_ROVR = 11;
    localparam int BIT_BB   = 12;

    localparam logic [DATA_W-1:0] STICKY_MASK =
        (DATA_W'(1) << BIT_AL)   | (DATA_W'(1) << BIT_NACK) |
        (DATA_W'(1) << BIT_ARDY) | (DATA_W'(1) << BIT_RRDY) |
        (DATA_W'(1) << BIT_XRDY) | (DATA_W'(1) << BIT_XUDF) |
        (DATA_W'(1) << BIT_ROVR);

    typedef enum logic [1:0] {
        ADDR_STAT = 2'd0,
        ADDR_IEN  = 2'd1,
        ADDR_VEC  = 2'd2,
        ADDR_RSVD = 2'd3
    } reg_addr_e;

endpackage

// File: rtl/ivu_status_bank.sv
module ivu_status_bank #(
    parameter int                DATA_W      = 16,
    parameter int                NUM_SRC     = 5,
    parameter logic [DATA_W-1:0] STICKY_MASK = 16'h0C1F
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [DATA_W-1:0]  set_i,
    input  logic [DATA_W-1:0]  clr_i,
    input  logic               ien_we_i,
    input  logic [NUM_SRC-1:0] ien_wdata_i,
    output logic [DATA_W-1:0]  stat_o,
    output logic [NUM_SRC-1:0] ien_o
);

    typedef struct packed {
        logic [DATA_W-1:0]  stat;
        logic [NUM_SRC-1:0] ien;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d      = bank_q;
        // set has priority over clear
        bank_d.stat = ((bank_q.stat & ~clr_i) | set_i) & STICKY_MASK;
        if (ien_we_i) begin
            bank_d.ien = ien_wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign stat_o = bank_q.stat;
    assign ien_o  = bank_q.ien;

    // R10
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((set_i & STICKY_MASK) != '0) |=>
        ((bank_q.stat & $past(set_i & STICKY_MASK)) == $past(set_i & STICKY_MASK)));

    // R3
    w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr_i & ~set_i & STICKY_MASK) != '0) |=>
        ((bank_q.stat & $past(clr_i & ~set_i)) == '0));

    // R2
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i == '0) |=>
        ((bank_q.stat & $past(bank_q.stat)) == $past(bank_q.stat)));

endmodule

// File: rtl/ivu_vec_encoder.sv
module ivu_vec_encoder #(
    parameter int NUM_SRC = 5,
    parameter int CODE_W  = $clog2(NUM_SRC + 1)
) (
    input  logic [NUM_SRC-1:0] pend_i,
    output logic [NUM_SRC-1:0] sel_o,
    output logic [CODE_W-1:0]  code_o
);

    logic [NUM_SRC:0] lower_any;

    assign lower_any[0] = 1'b0;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_prio
        assign sel_o[g]       = pend_i[g] & ~lower_any[g];
        assign lower_any[g+1] = lower_any[g] | pend_i[g];
    end

    always_comb begin
        code_o = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (sel_o[i]) begin
                code_o = code_o | CODE_W'(i + 1);
            end
        end
    end

    // R8
    always_comb begin
        vec_onehot_chk: assert ($onehot0(sel_o));
    end

    // R7
    always_comb begin
        vec_zero_chk: assert ((code_o == '0) == (pend_i == '0));
    end

endmodule

// File: rtl/i2c_irq_vec_unit.sv
module i2c_irq_vec_unit
    import i2civ_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_arb_lost,
    input  logic              ev_nack,
    input  logic              ev_acc_rdy,
    input  logic              ev_rx_rdy,
    input  logic              ev_tx_rdy,
    input  logic              ev_tx_udf,
    input  logic              ev_rx_ovr,
    input  logic              bus_busy,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq
);

    localparam int CODE_W = $clog2(NUM_SRC + 1);

    reg_addr_e          addr_sel;
    logic [DATA_W-1:0]  set_vec;
    logic [DATA_W-1:0]  clr_vec;
    logic [DATA_W-1:0]  stat_q;
    logic [DATA_W-1:0]  stat_view;
    logic [NUM_SRC-1:0] ien_q;
    logic [NUM_SRC-1:0] pend;
    logic [NUM_SRC-1:0] vec_sel;
    logic [CODE_W-1:0]  vec_code;
    logic               wr_stat;
    logic               wr_ien;
    logic               rd_vec;

    assign addr_sel = reg_addr_e'(reg_addr);
    assign wr_stat  = reg_wr && (addr_sel == ADDR_STAT);
    assign wr_ien   = reg_wr && (addr_sel == ADDR_IEN);
    assign rd_vec   = reg_rd && (addr_sel == ADDR_VEC);

    always_comb begin
        set_vec           = '0;
        set_vec[BIT_AL]   = ev_arb_lost;
        set_vec[BIT_NACK] = ev_nack;
        set_vec[BIT_ARDY] = ev_acc_rdy;
        set_vec[BIT_RRDY] = ev_rx_rdy;
        set_vec[BIT_XRDY] = ev_tx_rdy;
        set_vec[BIT_XUDF] = ev_tx_udf;
        set_vec[BIT_ROVR] = ev_rx_ovr;
    end

    always_comb begin
        clr_vec = wr_stat ? reg_wdata : '0;
        if (rd_vec) begin
            clr_vec = clr_vec | DATA_W'(vec_sel);
        end
    end

    ivu_status_bank #(
        .DATA_W     (DATA_W),
        .NUM_SRC    (NUM_SRC),
        .STICKY_MASK(STICKY_MASK)
    ) bank_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_i      (set_vec),
        .clr_i      (clr_vec),
        .ien_we_i   (wr_ien),
        .ien_wdata_i(reg_wdata[NUM_SRC-1:0]),
        .stat_o     (stat_q),
        .ien_o      (ien_q)
    );

    assign pend = stat_q[NUM_SRC-1:0] & ien_q;

    ivu_vec_encoder #(
        .NUM_SRC(NUM_SRC),
        .CODE_W (CODE_W)
    ) enc_i (
        .pend_i(pend),
        .sel_o (vec_sel),
        .code_o(vec_code)
    );

    always_comb begin
        stat_view         = stat_q;
        stat_view[BIT_BB] = bus_busy;
    end

    always_comb begin
        unique case (addr_sel)
            ADDR_STAT: reg_rdata = stat_view;
            ADDR_IEN:  reg_rdata = DATA_W'(ien_q);
            ADDR_VEC:  reg_rdata = DATA_W'(vec_code);
            default:   reg_rdata = '0;
        endcase
    end

    assign irq = |pend;

    // R6
    irq_vec_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (vec_code != '0));

    // R9
    vec_read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_vec && (vec_sel != '0) && ((set_vec[NUM_SRC-1:0] & vec_sel) == '0)) |=>
        ((stat_q[NUM_SRC-1:0] & $past(vec_sel)) == '0));

endmodule

// File: tb/i2c_irq_vec_unit_tb_top.sv
`timescale 1ns/1ps
module i2c_irq_vec_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  ev = '0;
    logic        bus_busy = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        irq;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    i2c_irq_vec_unit dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .ev_arb_lost(ev[0]),
        .ev_nack    (ev[1]),
        .ev_acc_rdy (ev[2]),
        .ev_rx_rdy  (ev[3]),
        .ev_tx_rdy  (ev[4]),
        .ev_tx_udf  (ev[5]),
        .ev_rx_ovr  (ev[6]),
        .bus_busy   (bus_busy),
        .reg_wr     (reg_wr),
        .reg_rd     (reg_rd),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .irq        (irq)
    );

    typedef struct packed {
        logic [6:0]  ev;
        logic [4:0]  en;
        logic [15:0] st;
        logic [2:0]  vec;
        logic        irq;
    } row_t;

    localparam int NROWS = 7;
    localparam row_t ROWS [NROWS] = '{
        '{7'h01, 5'h1F, 16'h0001, 3'd1, 1'b1},
        '{7'h02, 5'h00, 16'h0002, 3'd0, 1'b0},
        '{7'h1C, 5'h1F, 16'h001C, 3'd3, 1'b1},
        '{7'h60, 5'h1F, 16'h0C00, 3'd0, 1'b0},
        '{7'h18, 5'h10, 16'h0018, 3'd5, 1'b1},
        '{7'h7F, 5'h06, 16'h0C1F, 3'd2, 1'b1},
        '{7'h00, 5'h1F, 16'h0000, 3'd0, 1'b0}
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one access cycle, starting and ending at a falling edge
    task automatic access(input logic [6:0] evm, input logic wr, input logic rd,
                          input logic [1:0] addr, input logic [15:0] wd,
                          output logic [15:0] rdv);
        ev        = evm;
        reg_wr    = wr;
        reg_rd    = rd;
        reg_addr  = addr;
        reg_wdata = wd;
        #1 rdv = reg_rdata;
        @(posedge clk);
        @(negedge clk);
        ev     = '0;
        reg_wr = 1'b0;
        reg_rd = 1'b0;
    endtask

    task automatic wr_reg(input logic [1:0] addr, input logic [15:0] wd);
        logic [15:0] dummy;
        access('0, 1'b1, 1'b0, addr, wd, dummy);
    endtask

    task automatic rd_reg(input logic [1:0] addr, output logic [15:0] rdv);
        access('0, 1'b0, (addr == 2'd2), addr, '0, rdv);
    endtask

    task automatic pulse(input logic [6:0] evm);
        logic [15:0] dummy;
        access(evm, 1'b0, 1'b0, 2'd0, '0, dummy);
    endtask

    task automatic irq_chk(input string req, input logic exp);
        #1;
        check(req, {15'd0, irq}, {15'd0, exp});
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [15:0] r;
        logic [15:0] r2;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd_reg(2'd0, r); check("R1 status", r, 16'h0000);
        rd_reg(2'd1, r); check("R1 enable", r, 16'h0000);
        rd_reg(2'd2, r); check("R1 vector", r, 16'h0000);
        irq_chk("R1 irq", 1'b0);

        // table walk: R2, R6, R7
        for (int i = 0; i < NROWS; i++) begin
            wr_reg(2'd0, 16'hFFFF);
            wr_reg(2'd1, {11'd0, ROWS[i].en});
            pulse(ROWS[i].ev);
            rd_reg(2'd0, r); check($sformatf("R2 row%0d status", i), r, ROWS[i].st);
            irq_chk($sformatf("R6 row%0d irq", i), ROWS[i].irq);
            rd_reg(2'd2, r); check($sformatf("R7 row%0d vector", i), r, {13'd0, ROWS[i].vec});
        end

        // R4 bus busy
        wr_reg(2'd0, 16'hFFFF);
        bus_busy = 1'b1;
        rd_reg(2'd0, r); check("R4 bb high", r, 16'h1000);
        wr_reg(2'd0, 16'h1000);
        rd_reg(2'd0, r); check("R4 bb after write", r, 16'h1000);
        bus_busy = 1'b0;
        rd_reg(2'd0, r); check("R4 bb low", r, 16'h0000);

        // R3 write-one-to-clear
        pulse(7'h7F);
        wr_reg(2'd0, 16'h0005);
        rd_reg(2'd0, r); check("R3 partial clear", r, 16'h0C1A);
        wr_reg(2'd0, 16'h0000);
        rd_reg(2'd0, r); check("R3 zero write", r, 16'h0C1A);

        // R9 status read does not clear
        rd_reg(2'd0, r2); check("R9 status reread", r2, 16'h0C1A);

        // R10 set wins over write clear
        wr_reg(2'd0, 16'hFFFF);
        access(7'h01, 1'b1, 1'b0, 2'd0, 16'h0001, r);
        rd_reg(2'd0, r); check("R10 set vs w1c", r, 16'h0001);

        // R5 enable register width
        wr_reg(2'd1, 16'hFFFF);
        rd_reg(2'd1, r); check("R5 enable readback", r, 16'h001F);

        // R8 priority drain, R9 per-source clear
        wr_reg(2'd0, 16'hFFFF);
        pulse(7'h1A);
        rd_reg(2'd2, r); check("R8 first", r, 16'd2);
        rd_reg(2'd0, r); check("R9 only nack cleared", r, 16'h0018);
        rd_reg(2'd2, r); check("R8 second", r, 16'd4);
        rd_reg(2'd2, r); check("R8 third", r, 16'd5);
        rd_reg(2'd2, r); check("R8 empty", r, 16'd0);
        irq_chk("R6 irq after drain", 1'b0);

        // R10 set wins over vector read
        pulse(7'h02);
        access(7'h02, 1'b0, 1'b1, 2'd2, '0, r); check("R10 vector code", r, 16'd2);
        rd_reg(2'd0, r); check("R10 set vs vector read", r, 16'h0002);

        // R6 overrun/underflow never interrupt
        wr_reg(2'd0, 16'hFFFF);
        pulse(7'h60);
        irq_chk("R6 ovr no irq", 1'b0);

        // R11 writes to vector and reserved addresses ignored
        wr_reg(2'd1, 16'h0003);
        wr_reg(2'd2, 16'hFFFF);
        wr_reg(2'd3, 16'hFFFF);
        rd_reg(2'd0, r); check("R11 status kept", r, 16'h0C00);
        rd_reg(2'd1, r); check("R11 enable kept", r, 16'h0003);
        rd_reg(2'd3, r); check("R11 reserved reads zero", r, 16'h0000);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule